// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block is a circular window of in-flight instructions. Execution units may finish out of program order, but architectural register state changes only in program order. The decode stage claims a slot at the tail, one per cycle, and gets that slot's index back in the same cycle. Later, an execution unit names the slot by that index and deposits its result together with an exception flag. The oldest slot drains to a register-file write port once its result is present. A younger slot waits, even if its result arrived earlier.

When the oldest slot holds a finished instruction that raised an exception, nothing is written. The block presents a trap request carrying that instruction's PC and empties the whole window at the following clock edge. At that point every older instruction has already written its result and no younger one has. Consumers waiting on a pending result can look up any slot by index, in parallel with the register file read, and learn whether the value is ready.

Top module: `inorder_commit_buffer`

## Requirements
- R1: After reset the window is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `rf_we`, `exc_valid` and `lk_hit` are 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` high at a clock edge) takes the slot shown on `alloc_idx` in that cycle. Successive allocations take successive indices, modulo 16.
- R3: With 16 slots occupied, `alloc_ready` is 0. A request made while full changes no state, and `alloc_idx` keeps its value.
- R4: A completion (`cmp_valid`) to an occupied slot stores `cmp_data` and `cmp_exc` at the clock edge. From the next cycle `lk_hit` is 1 and `lk_data` shows that value for that slot's `lk_idx`.
- R5: `rf_we` is high, combinationally, in every cycle in which the oldest slot is finished without exception and requests a register write. `rf_waddr` and `rf_wdata` then carry its destination and result. A finished younger slot never drives the port.
- R6: At most one slot leaves per cycle, and register writes appear in allocation order.
- R7: A finished oldest slot allocated with `alloc_wen` = 0 leaves the window without asserting `rf_we`, and the next slot may then drain.
- R8: When the oldest slot is finished and flagged, `exc_valid` is 1 with `exc_pc` equal to its PC, and `rf_we` and `alloc_ready` are 0. After that edge the window is empty and `alloc_idx` is 0.
- R9: A flagged slot that is not the oldest raises nothing until every older slot has drained. Completed younger slots are discarded without writing.
- R10: A completion to a slot that is not occupied is ignored. The slot stays not ready on lookup, and it stays unfinished if it is allocated later.
- R11: A lookup of an occupied slot whose result has not arrived returns `lk_hit` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_ready | output | 1 | A slot can be granted this cycle |
| alloc_dest | input | 5 | Destination architectural register |
| alloc_wen | input | 1 | Instruction writes a register |
| alloc_pc | input | 32 | PC of the instruction |
| alloc_idx | output | 4 | Index of the slot being granted |
| cmp_valid | input | 1 | Execution result available |
| cmp_idx | input | 4 | Slot the result belongs to |
| cmp_data | input | 32 | Result value |
| cmp_exc | input | 1 | Instruction raised an exception |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| exc_valid | output | 1 | Precise trap request |
| exc_pc | output | 32 | PC of the trapping instruction |
| lk_idx | input | 4 | Slot to look up |
| lk_hit | output | 1 | Looked-up slot holds a ready result |
| lk_data | output | 32 | Result held by the looked-up slot |

## Verification
Results are returned in reverse and interleaved order. This shows whether draining is gated on the oldest slot alone, and not on any finished slot. A full window with requests held high separates a true full condition from an empty one, because the wrapped tail index equals the head index. A flagged instruction placed in the middle of a full window, with finished slots on both sides, shows that the older ones write, the younger ones are dropped, and the trap reports the right PC. Completions aimed at free slots and a long random mix of allocations, completions, lookups and rare exceptions are checked every cycle against a behavioural model of the window.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    // What the oldest slot does in the current cycle.
    typedef enum logic [1:0] {
        HEAD_IDLE   = 2'd0,
        HEAD_RETIRE = 2'd1,
        HEAD_TRAP   = 2'd2
    } head_act_e;

endpackage

// File: rtl/rcb_ptr_ctrl.sv
module rcb_ptr_ctrl #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic             retire_fire,
    input  logic             flush,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);

    // Pointers carry one wrap bit above the index.
    typedef struct packed {
        logic [IDX_W:0] head;
        logic [IDX_W:0] tail;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d.head = '0;
            ptr_d.tail = '0;
        end else begin
            if (alloc_fire)  ptr_d.tail = ptr_q.tail + 1'b1;
            if (retire_fire) ptr_d.head = ptr_q.head + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign head_idx = ptr_q.head[IDX_W-1:0];
    assign tail_idx = ptr_q.tail[IDX_W-1:0];
    assign empty    = (ptr_q.head == ptr_q.tail);
    assign full     = (ptr_q.head[IDX_W] != ptr_q.tail[IDX_W]) &&
                      (ptr_q.head[IDX_W-1:0] == ptr_q.tail[IDX_W-1:0]);

    // Checking support: marks the cycles after the first post-reset edge.
    logic           seen_q;
    logic [IDX_W:0] occ;
    assign occ = ptr_q.tail - ptr_q.head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r3_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_fire);

    a_r6_no_retire_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !retire_fire);

    a_r6_occupancy_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(flush)) |->
            (occ == $past(occ) + (IDX_W+1)'($past(alloc_fire)) - (IDX_W+1)'($past(retire_fire))));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(flush)) |-> (empty && head_idx == '0));

endmodule

// File: rtl/rcb_entry_array.sv
module rcb_entry_array #(
    parameter int DEPTH  = 16,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_fire,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [AREG_W-1:0] alloc_dest,
    input  logic              alloc_wen,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic              cmp_exc,
    input  logic              retire_fire,
    input  logic              flush,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              head_valid,
    output logic              head_done,
    output logic              head_exc,
    output logic              head_wen,
    output logic [AREG_W-1:0] head_dest,
    output logic [DATA_W-1:0] head_data,
    output logic [PC_W-1:0]   head_pc,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data
);

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              exc;
        logic              wen;
        logic [AREG_W-1:0] dest;
        logic [DATA_W-1:0] data;
        logic [PC_W-1:0]   pc;
    } slot_t;

    logic [DEPTH-1:0]  vld_vec;
    logic [DEPTH-1:0]  done_vec;
    logic [DEPTH-1:0]  exc_vec;
    logic [DEPTH-1:0]  wen_vec;
    logic [AREG_W-1:0] dest_arr [DEPTH];
    logic [DATA_W-1:0] data_arr [DEPTH];
    logic [PC_W-1:0]   pc_arr   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            // Result write, only into an occupied slot.
            if (cmp_valid && cmp_idx == IDX_W'(i) && slot_q.valid) begin
                slot_d.done = 1'b1;
                slot_d.exc  = cmp_exc;
                slot_d.data = cmp_data;
            end
            // Leaving the window frees the slot.
            if (retire_fire && head_idx == IDX_W'(i)) begin
                slot_d.valid = 1'b0;
                slot_d.done  = 1'b0;
                slot_d.exc   = 1'b0;
            end
            // Fresh claim at the tail.
            if (alloc_fire && alloc_idx == IDX_W'(i)) begin
                slot_d.valid = 1'b1;
                slot_d.done  = 1'b0;
                slot_d.exc   = 1'b0;
                slot_d.wen   = alloc_wen;
                slot_d.dest  = alloc_dest;
                slot_d.pc    = alloc_pc;
                slot_d.data  = '0;
            end
            // A trap discards every slot.
            if (flush) begin
                slot_d.valid = 1'b0;
                slot_d.done  = 1'b0;
                slot_d.exc   = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign vld_vec[i]  = slot_q.valid;
        assign done_vec[i] = slot_q.done;
        assign exc_vec[i]  = slot_q.exc;
        assign wen_vec[i]  = slot_q.wen;
        assign dest_arr[i] = slot_q.dest;
        assign data_arr[i] = slot_q.data;
        assign pc_arr[i]   = slot_q.pc;
    end

    assign head_valid = vld_vec[head_idx];
    assign head_done  = done_vec[head_idx];
    assign head_exc   = exc_vec[head_idx];
    assign head_wen   = wen_vec[head_idx];
    assign head_dest  = dest_arr[head_idx];
    assign head_data  = data_arr[head_idx];
    assign head_pc    = pc_arr[head_idx];

    assign lk_hit  = vld_vec[lk_idx] && done_vec[lk_idx];
    assign lk_data = data_arr[lk_idx];

    a_r10_ignore_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !vld_vec[cmp_idx]) |=> !done_vec[$past(cmp_idx)]);

    a_r4_result_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && vld_vec[cmp_idx] && !flush && !(retire_fire && head_idx == cmp_idx))
            |=> (done_vec[$past(cmp_idx)] && data_arr[$past(cmp_idx)] == $past(cmp_data)));

    a_r5_retire_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
        retire_fire |-> (head_valid && head_done && !head_exc));

endmodule

// File: rtl/rcb_commit_ctrl.sv
module rcb_commit_ctrl
    import rcb_pkg::*;
#(
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32
) (
    input  logic              empty,
    input  logic              head_valid,
    input  logic              head_done,
    input  logic              head_exc,
    input  logic              head_wen,
    input  logic [AREG_W-1:0] head_dest,
    input  logic [DATA_W-1:0] head_data,
    input  logic [PC_W-1:0]   head_pc,
    output logic              retire_fire,
    output logic              flush,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              exc_valid,
    output logic [PC_W-1:0]   exc_pc
);

    head_act_e act;

    always_comb begin
        act = HEAD_IDLE;
        if (!empty && head_valid && head_done) begin
            act = head_exc ? HEAD_TRAP : HEAD_RETIRE;
        end
    end

    assign retire_fire = (act == HEAD_RETIRE);
    assign flush       = (act == HEAD_TRAP);
    assign rf_we       = retire_fire && head_wen;
    assign rf_waddr    = head_dest;
    assign rf_wdata    = head_data;
    assign exc_valid   = flush;
    assign exc_pc      = head_pc;

endmodule

// File: rtl/inorder_commit_buffer.sv
module inorder_commit_buffer #(
    parameter int DEPTH  = 16,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [AREG_W-1:0] alloc_dest,
    input  logic              alloc_wen,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic              cmp_exc,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              exc_valid,
    output logic [PC_W-1:0]   exc_pc,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data
);

    logic             alloc_fire;
    logic             retire_fire;
    logic             flush;
    logic             full;
    logic             empty;
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] tail_idx;

    logic              head_valid;
    logic              head_done;
    logic              head_exc;
    logic              head_wen;
    logic [AREG_W-1:0] head_dest;
    logic [DATA_W-1:0] head_data;
    logic [PC_W-1:0]   head_pc;

    assign alloc_ready = !full && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_idx   = tail_idx;

    rcb_ptr_ctrl #(
        .DEPTH (DEPTH)
    ) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .retire_fire (retire_fire),
        .flush       (flush),
        .head_idx    (head_idx),
        .tail_idx    (tail_idx),
        .full        (full),
        .empty       (empty)
    );

    rcb_entry_array #(
        .DEPTH  (DEPTH),
        .AREG_W (AREG_W),
        .DATA_W (DATA_W),
        .PC_W   (PC_W)
    ) slots_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .alloc_idx   (tail_idx),
        .alloc_dest  (alloc_dest),
        .alloc_wen   (alloc_wen),
        .alloc_pc    (alloc_pc),
        .cmp_valid   (cmp_valid),
        .cmp_idx     (cmp_idx),
        .cmp_data    (cmp_data),
        .cmp_exc     (cmp_exc),
        .retire_fire (retire_fire),
        .flush       (flush),
        .head_idx    (head_idx),
        .lk_idx      (lk_idx),
        .head_valid  (head_valid),
        .head_done   (head_done),
        .head_exc    (head_exc),
        .head_wen    (head_wen),
        .head_dest   (head_dest),
        .head_data   (head_data),
        .head_pc     (head_pc),
        .lk_hit      (lk_hit),
        .lk_data     (lk_data)
    );

    rcb_commit_ctrl #(
        .AREG_W (AREG_W),
        .DATA_W (DATA_W),
        .PC_W   (PC_W)
    ) commit_i (
        .empty       (empty),
        .head_valid  (head_valid),
        .head_done   (head_done),
        .head_exc    (head_exc),
        .head_wen    (head_wen),
        .head_dest   (head_dest),
        .head_data   (head_data),
        .head_pc     (head_pc),
        .retire_fire (retire_fire),
        .flush       (flush),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .exc_valid   (exc_valid),
        .exc_pc      (exc_pc)
    );

    a_r8_trap_blocks_port: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (!rf_we && !alloc_ready));

    a_r2_tail_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !flush) |=> (alloc_idx == $past(alloc_idx) + 1'b1));

endmodule

// File: tb/inorder_commit_buffer_tb.sv
`timescale 1ns/1ps
module inorder_commit_buffer_tb_top;

    localparam int DEPTH      = 16;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid;
    logic        alloc_ready;
    logic [4:0]  alloc_dest;
    logic        alloc_wen;
    logic [31:0] alloc_pc;
    logic [3:0]  alloc_idx;
    logic        cmp_valid;
    logic [3:0]  cmp_idx;
    logic [31:0] cmp_data;
    logic        cmp_exc;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        exc_valid;
    logic [31:0] exc_pc;
    logic [3:0]  lk_idx;
    logic        lk_hit;
    logic [31:0] lk_data;

    always #10 clk = ~clk;

    inorder_commit_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_dest(alloc_dest),
        .alloc_wen(alloc_wen), .alloc_pc(alloc_pc), .alloc_idx(alloc_idx),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .exc_valid(exc_valid), .exc_pc(exc_pc),
        .lk_idx(lk_idx), .lk_hit(lk_hit), .lk_data(lk_data)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural model of the window.
    logic        m_valid [DEPTH];
    logic        m_done  [DEPTH];
    logic        m_exc   [DEPTH];
    logic        m_wen   [DEPTH];
    logic [4:0]  m_dest  [DEPTH];
    logic [31:0] m_data  [DEPTH];
    logic [31:0] m_pc    [DEPTH];
    int          m_head = 0;
    int          m_cnt  = 0;

    int          retired_q [$];
    int          trap_seen = 0;
    logic [31:0] trap_pc   = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_done[i] = 1'b0; m_exc[i] = 1'b0;
            m_wen[i] = 1'b0; m_dest[i] = '0; m_data[i] = '0; m_pc[i] = '0;
        end
        m_head = 0;
        m_cnt  = 0;
    endtask

    function automatic logic m_trap();
        return (m_cnt > 0) && m_valid[m_head] && m_done[m_head] && m_exc[m_head];
    endfunction

    task automatic compare();
        logic exp_we;
        exp_we = (m_cnt > 0) && m_done[m_head] && !m_exc[m_head] && m_wen[m_head];
        chk("R3", "alloc_ready", alloc_ready, (m_cnt < DEPTH) && !m_trap());
        chk("R2", "alloc_idx", alloc_idx, (m_head + m_cnt) % DEPTH);
        chk("R5", "rf_we", rf_we, exp_we);
        if (exp_we) begin
            chk("R5", "rf_waddr", rf_waddr, m_dest[m_head]);
            chk("R5", "rf_wdata", rf_wdata, m_data[m_head]);
        end
        chk("R8", "exc_valid", exc_valid, m_trap());
        if (m_trap()) chk("R8", "exc_pc", exc_pc, m_pc[m_head]);
        chk("R4", "lk_hit", lk_hit, m_valid[lk_idx] && m_done[lk_idx]);
        if (m_valid[lk_idx] && m_done[lk_idx]) chk("R4", "lk_data", lk_data, m_data[lk_idx]);
        if (rf_we === 1'b1) retired_q.push_back(int'(rf_waddr));
        if (exc_valid === 1'b1) begin
            trap_seen++;
            trap_pc = exc_pc;
        end
    endtask

    task automatic model_update();
        int h;
        int c;
        int slot;
        logic ret;
        h = m_head;
        c = m_cnt;
        if (m_trap()) begin
            model_clear();
        end else begin
            ret = (c > 0) && m_done[h];
            if (cmp_valid && m_valid[cmp_idx]) begin
                m_done[cmp_idx] = 1'b1;
                m_exc[cmp_idx]  = cmp_exc;
                m_data[cmp_idx] = cmp_data;
            end
            if (ret) begin
                m_valid[h] = 1'b0; m_done[h] = 1'b0; m_exc[h] = 1'b0;
                m_head = (h + 1) % DEPTH;
                m_cnt--;
            end
            if (alloc_valid && c < DEPTH) begin
                slot = (h + c) % DEPTH;
                m_valid[slot] = 1'b1; m_done[slot] = 1'b0; m_exc[slot] = 1'b0;
                m_wen[slot] = alloc_wen; m_dest[slot] = alloc_dest; m_pc[slot] = alloc_pc;
                m_cnt++;
            end
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 1'b0; alloc_dest = '0; alloc_wen = 1'b0; alloc_pc = '0;
        cmp_valid = 1'b0; cmp_idx = '0; cmp_data = '0; cmp_exc = 1'b0;
    endtask

    // One clock: compare outputs, take the edge, update the model, return at negedge.
    task automatic step();
        #1;
        compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_alloc(input logic [4:0] d, input logic w, input logic [31:0] pc, output int idx);
        idx = (m_head + m_cnt) % DEPTH;
        alloc_valid = 1'b1; alloc_dest = d; alloc_wen = w; alloc_pc = pc;
        step();
    endtask

    task automatic do_cmp(input int idx, input logic [31:0] data, input logic e);
        cmp_valid = 1'b1; cmp_idx = 4'(idx); cmp_data = data; cmp_exc = e;
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic check_retired(string req, int first, int n);
        chk(req, "retire count", retired_q.size(), n);
        for (int i = 0; i < n && i < retired_q.size(); i++)
            chk(req, "retire order", retired_q[i], first + i);
    endtask

    initial begin
        #(WD_CYCLES * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int q[16];
        int slot_x;
        rst_n = 1'b0;
        lk_idx = '0;
        idle_inputs();
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        #1;
        chk("R1", "alloc_ready", alloc_ready, 1);
        chk("R1", "alloc_idx", alloc_idx, 0);
        chk("R1", "rf_we", rf_we, 0);
        chk("R1", "exc_valid", exc_valid, 0);
        chk("R1", "lk_hit", lk_hit, 0);

        // R5/R6: out-of-order results, in-order writes
        for (int i = 0; i < 4; i++) do_alloc(5'(i + 1), 1'b1, 32'h100 + 32'(4 * i), q[i]);
        retired_q.delete();
        do_cmp(q[2], 32'hA2, 1'b0);
        #1 chk("R5", "younger finished slot waits", rf_we, 0);
        do_cmp(q[1], 32'hA1, 1'b0);
        do_cmp(q[3], 32'hA3, 1'b0);
        do_cmp(q[0], 32'hA0, 1'b0);
        idle(5);
        check_retired("R6", 1, 4);

        // R7: slot without a register write
        retired_q.delete();
        do_alloc(5'd9, 1'b0, 32'h200, q[0]);
        do_alloc(5'd10, 1'b1, 32'h204, q[1]);
        do_cmp(q[0], 32'hB0, 1'b0);
        do_cmp(q[1], 32'hB1, 1'b0);
        idle(3);
        check_retired("R7", 10, 1);

        // R3/R11: fill the window
        for (int i = 0; i < DEPTH; i++) do_alloc(5'(16 + i), 1'b1, 32'h1000 + 32'(4 * i), q[i]);
        #1 chk("R3", "ready when full", alloc_ready, 0);
        alloc_valid = 1'b1; alloc_dest = 5'd31; alloc_wen = 1'b1; alloc_pc = 32'hDEAD;
        step();
        alloc_valid = 1'b1; alloc_dest = 5'd31; alloc_wen = 1'b1; alloc_pc = 32'hDEAD;
        step();
        #1 chk("R3", "index held while full", alloc_idx, q[0]);
        lk_idx = 4'(q[3]);
        #1 chk("R11", "pending slot lookup", lk_hit, 0);

        // R8/R9: flagged slot in the middle
        retired_q.delete();
        trap_seen = 0;
        do_cmp(q[5], 32'hE5, 1'b1);
        do_cmp(q[6], 32'hC6, 1'b0);
        do_cmp(q[7], 32'hC7, 1'b0);
        for (int i = 0; i < 5; i++) do_cmp(q[i], 32'hC0 + 32'(i), 1'b0);
        idle(4);
        check_retired("R9", 16, 5);
        chk("R8", "trap count", trap_seen, 1);
        chk("R8", "trap pc", trap_pc, 32'h1000 + 32'(4 * 5));
        lk_idx = 4'(q[6]);
        #1;
        chk("R8", "ready after trap", alloc_ready, 1);
        chk("R8", "index after trap", alloc_idx, 0);
        chk("R9", "younger slot discarded", lk_hit, 0);

        // R10: completion to a free slot
        do_cmp(5, 32'h55, 1'b0);
        lk_idx = 4'd5;
        #1 chk("R10", "free slot lookup", lk_hit, 0);
        retired_q.delete();
        for (int i = 0; i < 6; i++) do_alloc(5'(i + 1), 1'b1, 32'h300 + 32'(4 * i), q[i]);
        for (int i = 0; i < 5; i++) do_cmp(q[i], 32'hD0 + 32'(i), 1'b0);
        idle(7);
        check_retired("R10", 1, 5);
        #1 chk("R10", "stale completion not kept", lk_hit, 0);
        do_cmp(q[5], 32'hD5, 1'b0);
        idle(2);
        check_retired("R10", 1, 6);

        // Random mix checked against the model every cycle
        for (int n = 0; n < 500; n++) begin
            alloc_valid = ($urandom % 2) == 0;
            alloc_dest  = 5'($urandom);
            alloc_wen   = ($urandom % 4) != 0;
            alloc_pc    = $urandom;
            cmp_valid   = ($urandom % 5) < 3;
            if (($urandom % 10) < 8 && m_cnt > 0)
                slot_x = (m_head + int'($urandom % m_cnt)) % DEPTH;
            else
                slot_x = int'($urandom % DEPTH);
            cmp_idx  = 4'(slot_x);
            cmp_data = $urandom;
            cmp_exc  = ($urandom % 25) == 0;
            lk_idx   = 4'($urandom);
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule